// File: doc/BRIEF.md
# SPI Pin Steering and Direction Control

This block sits between an SPI shift engine and the four external pads (MOSI, MISO, SCK, SS). For every pad it computes the value to drive and the output enable. It also chooses which pad feeds the engine's serial input. Two wiring styles are supported, for either role. In the four-wire style, data leaves on one pad and arrives on another. In the single-wire style, one shared data pad carries both directions: MOSI when the block is a master, MISO when it is a slave.

The block also decides who owns the select pad. A slave always treats SS as its select input. A master either hands SS back to general-purpose I/O, drives it low as a select output for the whole transfer, or watches it as a fault input. In the fault case, a low level raises a sticky fault flag and turns off every output driver. The SS pad passes through a reset-to-high synchronizer before any logic uses it. Reset is applied asynchronously and released on a clock edge.

Top module: `spi_pin_steer`

## Requirements
- R1: Master, four-wire (`cfg_bidir`=0), no fault: MOSI drives `eng_sdo` with its enable at 1, the MISO enable is 0, and `eng_sdi` follows `pad_miso_in`.
- R2: Slave, four-wire: `eng_sdi` follows `pad_mosi_in`, the MOSI enable is 0 and `pad_miso_out` follows `eng_sdo`. The MISO enable is 1 only while the synchronized SS is low. It rises at the second rising clock edge after `pad_ss_in` falls, and falls at the second rising edge after `pad_ss_in` rises.
- R3: Master, single-wire (`cfg_bidir`=1): `eng_sdi` follows `pad_mosi_in`, the MOSI enable equals `cfg_bidir_oe` (1 = drive, 0 = input), and the MISO enable is 0.
- R4: Slave, single-wire: `eng_sdi` follows `pad_miso_in`, the MISO enable equals `cfg_bidir_oe` regardless of SS, and the MOSI enable is 0.
- R5: With `cfg_bidir`=0, `cfg_bidir_oe` has no effect on any pad output or on `eng_sdi`.
- R6: A master drives SCK (`pad_sck_oe`=1, `pad_sck_out`=`eng_sck`). A slave never drives SCK or MOSI. `eng_sck_rx` always follows `pad_sck_in`.
- R7: In slave role, `pad_ss_oe`=0 and `ss_released`=0 whatever `cfg_fault_en` and `cfg_ss_out_en` hold. `eng_slave_sel` is 1 while the synchronized SS is low.
- R8: Master with `cfg_fault_en`=0: `ss_released`=1, `pad_ss_oe`=0, and SS low never sets `mode_fault`.
- R9: Master with `cfg_fault_en`=1 and `cfg_ss_out_en`=1: `pad_ss_oe`=1 and `pad_ss_out` is low exactly while `eng_busy` is 1. SS input levels are ignored.
- R10: Master with `cfg_fault_en`=1 and `cfg_ss_out_en`=0: `mode_fault` rises at the third rising edge after `pad_ss_in` falls. While it is set, every pad output enable is 0. It stays set after SS returns high, and clears at the first rising edge after the block leaves this configuration.
- R11: After reset, `mode_fault`=0 and the synchronized SS reads high, so a slave leaves MISO undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_bidir | input | 1 | 1 = single-wire data, 0 = four-wire |
| cfg_bidir_oe | input | 1 | Shared data pad drive enable in single-wire style |
| cfg_fault_en | input | 1 | Master: 1 = SS owned by SPI, 0 = SS released |
| cfg_ss_out_en | input | 1 | Master with SS owned: 1 = select output, 0 = fault input |
| eng_busy | input | 1 | Transfer in progress |
| eng_sdo | input | 1 | Serial data from the shift engine |
| eng_sck | input | 1 | Serial clock from the clock generator |
| eng_sdi | output | 1 | Serial data to the shift engine |
| eng_sck_rx | output | 1 | SCK pad level to the engine |
| eng_slave_sel | output | 1 | Slave selected (synchronized SS low) |
| pad_mosi_in | input | 1 | MOSI pad input |
| pad_mosi_out | output | 1 | MOSI pad output value |
| pad_mosi_oe | output | 1 | MOSI pad output enable |
| pad_miso_in | input | 1 | MISO pad input |
| pad_miso_out | output | 1 | MISO pad output value |
| pad_miso_oe | output | 1 | MISO pad output enable |
| pad_sck_in | input | 1 | SCK pad input |
| pad_sck_out | output | 1 | SCK pad output value |
| pad_sck_oe | output | 1 | SCK pad output enable |
| pad_ss_in | input | 1 | SS pad input |
| pad_ss_out | output | 1 | SS pad output value |
| pad_ss_oe | output | 1 | SS pad output enable |
| ss_released | output | 1 | SS pad handed to general-purpose I/O |
| mode_fault | output | 1 | Sticky master mode-fault flag |

## Verification
The bench toggles `cfg_bidir_oe` while the four-wire style is selected. A design that let it leak would tri-state MOSI or light MISO for a master. It counts edges after SS moves, so a design with the wrong synchronizer depth would enable a slave's MISO or flag a fault one cycle early or late. It holds SS low in the released and select-output configurations, where a careless design would raise a false fault. It then checks that a real fault survives SS going high, blanks all drivers, and clears only when the configuration changes.

// File: rtl/spi_pin_pkg.sv
package spi_pin_pkg;

  // Combined role and data wiring style
  typedef enum logic [1:0] {
    WIRE_SLV_QUAD = 2'b00,
    WIRE_SLV_MONO = 2'b01,
    WIRE_MST_QUAD = 2'b10,
    WIRE_MST_MONO = 2'b11
  } wire_mode_e;

  // How the select pad is used
  typedef enum logic [1:0] {
    SEL_SLAVE_IN = 2'b00,
    SEL_GPIO     = 2'b01,
    SEL_DRIVE    = 2'b10,
    SEL_FAULT_IN = 2'b11
  } sel_use_e;

  typedef struct packed {
    logic mosi_out;
    logic mosi_oe;
    logic miso_out;
    logic miso_oe;
    logic sck_out;
    logic sck_oe;
  } pad_drive_t;

  function automatic wire_mode_e wire_mode(input logic master, input logic bidir);
    return wire_mode_e'({master, bidir});
  endfunction

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] rel_q;
  logic [STAGES-1:0] rel_d;

  always_comb begin
    rel_d = {rel_q[STAGES-1:0], 1'b1} >> 0;
    rel_d = (STAGES > 1) ? {rel_q, 1'b1} : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= '0;
    else        rel_q <= rel_d;
  end

  assign rst_sync_n = rel_q[STAGES-1];
endmodule

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES:0]   chain_ext;

  assign chain_ext = {chain_q, d};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b1;
      else        chain_q[g] <= chain_ext[g];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_data_route.sv
module spi_data_route
  import spi_pin_pkg::*;
(
  input  wire_mode_e mode,
  input  logic       bidir_oe,
  input  logic       slave_sel,
  input  logic       fault,
  input  logic       eng_sdo,
  input  logic       eng_sck,
  input  logic       pad_mosi_in,
  input  logic       pad_miso_in,
  output pad_drive_t drive,
  output logic       eng_sdi
);
  pad_drive_t raw;

  always_comb begin
    raw          = '0;
    raw.sck_out  = eng_sck;
    raw.mosi_out = eng_sdo;
    raw.miso_out = eng_sdo;
    eng_sdi      = 1'b0;
    unique case (mode)
      WIRE_MST_QUAD: begin
        raw.mosi_oe = 1'b1;
        raw.sck_oe  = 1'b1;
        eng_sdi     = pad_miso_in;
      end
      WIRE_MST_MONO: begin
        raw.mosi_oe = bidir_oe;
        raw.sck_oe  = 1'b1;
        eng_sdi     = pad_mosi_in;
      end
      WIRE_SLV_QUAD: begin
        raw.miso_oe = slave_sel;
        eng_sdi     = pad_mosi_in;
      end
      WIRE_SLV_MONO: begin
        raw.miso_oe = bidir_oe;
        eng_sdi     = pad_miso_in;
      end
      default: ;
    endcase
  end

  always_comb begin
    drive = raw;
    if (fault) begin
      drive.mosi_oe = 1'b0;
      drive.miso_oe = 1'b0;
      drive.sck_oe  = 1'b0;
    end
  end
endmodule

// File: rtl/spi_ss_ctrl.sv
module spi_ss_ctrl
  import spi_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic fault_en,
  input  logic ss_out_en,
  input  logic busy,
  input  logic ss_sync,
  output logic ss_out,
  output logic ss_oe,
  output logic released,
  output logic slave_sel,
  output logic fault
);
  sel_use_e use_c;
  logic     fault_q;
  logic     fault_d;
  logic     fault_ce;

  always_comb begin
    if (!master)        use_c = SEL_SLAVE_IN;
    else if (!fault_en) use_c = SEL_GPIO;
    else if (ss_out_en) use_c = SEL_DRIVE;
    else                use_c = SEL_FAULT_IN;
  end

  // Next state: sticky while watching SS, cleared on leaving that use
  always_comb begin
    fault_d  = (use_c == SEL_FAULT_IN) && (fault_q || !ss_sync);
    fault_ce = (fault_d != fault_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault_q <= 1'b0;
    else if (fault_ce) fault_q <= fault_d;
  end

  always_comb begin
    ss_oe     = (use_c == SEL_DRIVE) && !fault_q;
    ss_out    = (use_c == SEL_DRIVE) ? !busy : 1'b1;
    released  = (use_c == SEL_GPIO);
    slave_sel = (use_c == SEL_SLAVE_IN) && !ss_sync;
  end

  assign fault = fault_q;
endmodule

// File: rtl/spi_pin_steer.sv
module spi_pin_steer
  import spi_pin_pkg::*;
#(
  parameter int SS_SYNC_STAGES  = 2,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master,
  input  logic cfg_bidir,
  input  logic cfg_bidir_oe,
  input  logic cfg_fault_en,
  input  logic cfg_ss_out_en,
  input  logic eng_busy,
  input  logic eng_sdo,
  input  logic eng_sck,
  output logic eng_sdi,
  output logic eng_sck_rx,
  output logic eng_slave_sel,
  input  logic pad_mosi_in,
  output logic pad_mosi_out,
  output logic pad_mosi_oe,
  input  logic pad_miso_in,
  output logic pad_miso_out,
  output logic pad_miso_oe,
  input  logic pad_sck_in,
  output logic pad_sck_out,
  output logic pad_sck_oe,
  input  logic pad_ss_in,
  output logic pad_ss_out,
  output logic pad_ss_oe,
  output logic ss_released,
  output logic mode_fault
);
  logic       rst_int_n;
  logic       ss_sync;
  logic       fault;
  logic       slave_sel;
  pad_drive_t drive;

  spi_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  spi_ss_sync #(.STAGES(SS_SYNC_STAGES)) u_ss_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pad_ss_in), .q(ss_sync)
  );

  spi_ss_ctrl u_ss_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .master(cfg_master), .fault_en(cfg_fault_en), .ss_out_en(cfg_ss_out_en),
    .busy(eng_busy), .ss_sync(ss_sync),
    .ss_out(pad_ss_out), .ss_oe(pad_ss_oe), .released(ss_released),
    .slave_sel(slave_sel), .fault(fault)
  );

  spi_data_route u_route (
    .mode(wire_mode(cfg_master, cfg_bidir)),
    .bidir_oe(cfg_bidir_oe), .slave_sel(slave_sel), .fault(fault),
    .eng_sdo(eng_sdo), .eng_sck(eng_sck),
    .pad_mosi_in(pad_mosi_in), .pad_miso_in(pad_miso_in),
    .drive(drive), .eng_sdi(eng_sdi)
  );

  assign pad_mosi_out  = drive.mosi_out;
  assign pad_mosi_oe   = drive.mosi_oe;
  assign pad_miso_out  = drive.miso_out;
  assign pad_miso_oe   = drive.miso_oe;
  assign pad_sck_out   = drive.sck_out;
  assign pad_sck_oe    = drive.sck_oe;
  assign eng_sck_rx    = pad_sck_in;
  assign eng_slave_sel = slave_sel;
  assign mode_fault    = fault;
endmodule

// File: rtl/spi_pin_steer_chk.sv
module spi_pin_steer_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_bidir,
  input logic cfg_bidir_oe,
  input logic cfg_fault_en,
  input logic cfg_ss_out_en,
  input logic eng_busy,
  input logic eng_sdo,
  input logic eng_sdi,
  input logic pad_miso_in,
  input logic pad_mosi_out,
  input logic pad_mosi_oe,
  input logic pad_miso_oe,
  input logic pad_sck_oe,
  input logic pad_ss_oe,
  input logic pad_ss_out,
  input logic ss_released,
  input logic mode_fault
);
  // R1
  mst_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !cfg_bidir && !mode_fault) |->
      (pad_mosi_oe && !pad_miso_oe && pad_mosi_out == eng_sdo && eng_sdi == pad_miso_in));

  // R3
  mst_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_bidir && !mode_fault) |-> (pad_mosi_oe == cfg_bidir_oe && !pad_miso_oe));

  // R4
  slv_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && cfg_bidir) |-> (pad_miso_oe == cfg_bidir_oe && !pad_mosi_oe));

  // R6
  slv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!pad_sck_oe && !pad_mosi_oe));

  // R7
  slv_ss_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!pad_ss_oe && !ss_released));

  // R8
  ss_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !cfg_fault_en) |-> (ss_released && !pad_ss_oe));

  // R8
  gpio_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !cfg_fault_en) |=> !mode_fault);

  // R9
  ss_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && cfg_fault_en && cfg_ss_out_en && !mode_fault) |->
      (pad_ss_oe && pad_ss_out == !eng_busy));

  // R10
  fault_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |-> (!pad_mosi_oe && !pad_miso_oe && !pad_sck_oe && !pad_ss_oe));

  // R10
  fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_fault) |-> $past(cfg_master && cfg_fault_en && !cfg_ss_out_en));
endmodule

bind spi_pin_steer spi_pin_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_master(cfg_master), .cfg_bidir(cfg_bidir), .cfg_bidir_oe(cfg_bidir_oe),
  .cfg_fault_en(cfg_fault_en), .cfg_ss_out_en(cfg_ss_out_en),
  .eng_busy(eng_busy), .eng_sdo(eng_sdo), .eng_sdi(eng_sdi),
  .pad_miso_in(pad_miso_in), .pad_mosi_out(pad_mosi_out), .pad_mosi_oe(pad_mosi_oe),
  .pad_miso_oe(pad_miso_oe), .pad_sck_oe(pad_sck_oe), .pad_ss_oe(pad_ss_oe),
  .pad_ss_out(pad_ss_out), .ss_released(ss_released), .mode_fault(mode_fault)
);

// File: tb/spi_pin_steer_bench.sv
module spi_pin_steer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cfg_master = 1'b0, cfg_bidir = 1'b0, cfg_bidir_oe = 1'b0;
  logic cfg_fault_en = 1'b0, cfg_ss_out_en = 1'b0;
  logic eng_busy = 1'b0, eng_sdo = 1'b0, eng_sck = 1'b0;
  logic pad_mosi_in = 1'b0, pad_miso_in = 1'b0, pad_sck_in = 1'b0, pad_ss_in = 1'b1;
  logic eng_sdi, eng_sck_rx, eng_slave_sel;
  logic pad_mosi_out, pad_mosi_oe, pad_miso_out, pad_miso_oe;
  logic pad_sck_out, pad_sck_oe, pad_ss_out, pad_ss_oe;
  logic ss_released, mode_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  spi_pin_steer u_spi_pin_steer (.*);

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    #2 rst_n = 1'b0;
    edges(2);
    chk("R11", "fault in reset", mode_fault, 1'b0);
    chk("R11", "slave miso_oe in reset", pad_miso_oe, 1'b0);
    rst_n = 1'b1;
    edges(4);
    chk("R11", "fault after reset", mode_fault, 1'b0);
    chk("R11", "slave deselected", eng_slave_sel, 1'b0);
  endtask

  task automatic t_master_quad;
    cfg_master = 1; cfg_bidir = 0; cfg_fault_en = 0; eng_sdo = 1; pad_miso_in = 0; eng_sck = 1;
    #1;
    chk("R1", "mosi_oe", pad_mosi_oe, 1'b1);
    chk("R1", "mosi_out", pad_mosi_out, 1'b1);
    chk("R1", "miso_oe", pad_miso_oe, 1'b0);
    chk("R1", "sdi low", eng_sdi, 1'b0);
    pad_miso_in = 1; pad_mosi_in = 0; #1;
    chk("R1", "sdi high", eng_sdi, 1'b1);
    chk("R6", "sck_oe", pad_sck_oe, 1'b1);
    chk("R6", "sck_out", pad_sck_out, 1'b1);
    cfg_bidir_oe = 1; #1;
    chk("R5", "mosi_oe oe=1", pad_mosi_oe, 1'b1);
    cfg_bidir_oe = 0; #1;
    chk("R5", "mosi_oe oe=0", pad_mosi_oe, 1'b1);
    chk("R5", "miso_oe oe=0", pad_miso_oe, 1'b0);
    chk("R5", "sdi oe=0", eng_sdi, 1'b1);
  endtask

  task automatic t_master_mono;
    cfg_master = 1; cfg_bidir = 1; cfg_bidir_oe = 1; pad_mosi_in = 1; pad_miso_in = 0;
    #1;
    chk("R3", "mosi_oe drive", pad_mosi_oe, 1'b1);
    chk("R3", "miso_oe", pad_miso_oe, 1'b0);
    chk("R3", "sdi from mosi", eng_sdi, 1'b1);
    cfg_bidir_oe = 0; #1;
    chk("R3", "mosi_oe input", pad_mosi_oe, 1'b0);
  endtask

  task automatic t_slave_quad;
    cfg_master = 0; cfg_bidir = 0; cfg_bidir_oe = 0; pad_ss_in = 1;
    edges(3);
    chk("R2", "miso_oe deselected", pad_miso_oe, 1'b0);
    chk("R6", "slave sck_oe", pad_sck_oe, 1'b0);
    chk("R6", "slave mosi_oe", pad_mosi_oe, 1'b0);
    pad_sck_in = 1; #1;
    chk("R6", "sck_rx", eng_sck_rx, 1'b1);
    pad_ss_in = 0;
    edges(1);
    chk("R2", "miso_oe after 1 edge", pad_miso_oe, 1'b0);
    edges(1);
    chk("R2", "miso_oe after 2 edges", pad_miso_oe, 1'b1);
    chk("R7", "slave_sel", eng_slave_sel, 1'b1);
    eng_sdo = 0; pad_mosi_in = 0; pad_miso_in = 1; #1;
    chk("R2", "miso_out", pad_miso_out, 1'b0);
    chk("R2", "sdi from mosi", eng_sdi, 1'b0);
    cfg_bidir_oe = 1; #1;
    chk("R5", "slave mosi_oe with oe=1", pad_mosi_oe, 1'b0);
    cfg_bidir_oe = 0;
    pad_ss_in = 1;
    edges(1);
    chk("R2", "miso_oe held 1 edge", pad_miso_oe, 1'b1);
    edges(1);
    chk("R2", "miso_oe off 2 edges", pad_miso_oe, 1'b0);
  endtask

  task automatic t_slave_mono;
    cfg_master = 0; cfg_bidir = 1; cfg_bidir_oe = 1; pad_miso_in = 1; pad_mosi_in = 0;
    #1;
    chk("R4", "miso_oe ss high", pad_miso_oe, 1'b1);
    chk("R4", "sdi from miso", eng_sdi, 1'b1);
    chk("R4", "mosi_oe", pad_mosi_oe, 1'b0);
    cfg_bidir_oe = 0; #1;
    chk("R4", "miso_oe input", pad_miso_oe, 1'b0);
  endtask

  task automatic t_slave_ss;
    cfg_master = 0; cfg_bidir = 0; cfg_fault_en = 1; cfg_ss_out_en = 1; pad_ss_in = 0;
    edges(3);
    chk("R7", "slave ss_oe", pad_ss_oe, 1'b0);
    chk("R7", "slave released", ss_released, 1'b0);
    chk("R7", "slave no fault", mode_fault, 1'b0);
    pad_ss_in = 1;
    edges(3);
  endtask

  task automatic t_master_gpio;
    cfg_master = 1; cfg_bidir = 0; cfg_fault_en = 0; cfg_ss_out_en = 0; pad_ss_in = 0;
    edges(4);
    chk("R8", "released", ss_released, 1'b1);
    chk("R8", "ss_oe", pad_ss_oe, 1'b0);
    chk("R8", "no fault", mode_fault, 1'b0);
    pad_ss_in = 1;
    edges(3);
  endtask

  task automatic t_master_drive;
    cfg_master = 1; cfg_fault_en = 1; cfg_ss_out_en = 1; eng_busy = 1; pad_ss_in = 0;
    edges(4);
    chk("R9", "ss_oe", pad_ss_oe, 1'b1);
    chk("R9", "ss_out busy", pad_ss_out, 1'b0);
    chk("R9", "no fault", mode_fault, 1'b0);
    eng_busy = 0; #1;
    chk("R9", "ss_out idle", pad_ss_out, 1'b1);
    pad_ss_in = 1;
    edges(3);
  endtask

  task automatic t_fault;
    cfg_master = 1; cfg_bidir = 0; cfg_fault_en = 1; cfg_ss_out_en = 0; pad_ss_in = 1;
    edges(3);
    chk("R10", "no fault ss high", mode_fault, 1'b0);
    pad_ss_in = 0;
    edges(2);
    chk("R10", "fault after 2 edges", mode_fault, 1'b0);
    chk("R10", "mosi_oe before fault", pad_mosi_oe, 1'b1);
    edges(1);
    chk("R10", "fault after 3 edges", mode_fault, 1'b1);
    chk("R10", "mosi_oe blanked", pad_mosi_oe, 1'b0);
    chk("R10", "sck_oe blanked", pad_sck_oe, 1'b0);
    chk("R10", "ss_oe blanked", pad_ss_oe, 1'b0);
    pad_ss_in = 1;
    edges(4);
    chk("R10", "fault sticky", mode_fault, 1'b1);
    cfg_fault_en = 0;
    edges(1);
    chk("R10", "fault cleared", mode_fault, 1'b0);
    chk("R10", "mosi_oe restored", pad_mosi_oe, 1'b1);
  endtask

  initial begin
    t_reset();
    t_master_quad();
    t_master_mono();
    t_slave_quad();
    t_slave_mono();
    t_slave_ss();
    t_master_gpio();
    t_master_drive();
    t_fault();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule